// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface

This block is a cycle-based model of the control side of a byte-wide flash memory. Four active-low control pins are sampled on every clock. Reset/powerdown, chip enable, output enable and write enable decide which of five bus modes applies: read, output disable, standby, deep powerdown or write. A write-mode cycle hands the byte on the data input to a command interpreter. That interpreter keeps the current read mode, which is array, identifier or status. It also runs the two-cycle unlock sequences for byte program and block erase.

An accepted program or erase starts an internal engine. The engine stays busy for a parameterised number of clock cycles, and the array changes only when it finishes. The array is a small register file that powers up erased (all 0xFF). Programming can only clear bits, so the stored byte becomes the old byte ANDed with the new data. An erase sets every byte of one block back to 0xFF.

Three inputs model the supply conditions. They gate what the interpreter accepts and whether the outputs are driven. The block is intended as a behavioural stand-in inside a larger system model. It drives a tri-state enable and a data byte that the surrounding pad logic turns into a bidirectional bus.

Top module: `flash_cui_core`

## Requirements
- R1: After the synchronous power-up reset, the read mode is array, `ry_by` is 1, `dq_oe` is 0, and every array byte reads 0xFF.
- R2: Bus modes are decoded with this priority: `rp_n` low gives deep powerdown; otherwise `ce_n` high gives standby; otherwise `oe_n` low gives read, whatever `we_n` is; otherwise `we_n` low gives write; otherwise output disable. `dq_oe` is 1 only in read mode. Each clock cycle spent in write mode delivers exactly one command byte.
- R3: Command 0xFF selects array read, 0x90 selects identifier read and 0x70 selects status read. In identifier mode, `addr[0]`=0 returns 0x89 and `addr[0]`=1 returns 0xA2.
- R4: The status byte holds engine ready (1 when idle) in bit 7, erase error in bit 5, write error in bit 4 and program-voltage error in bit 3. Bits 6 and 2..0 read 0. Command 0x50 clears bits 5, 4 and 3.
- R5: Writing 0x40 and then a data byte programs the byte at the second cycle's address to old AND data. The setup write switches the read mode to status. `ry_by` is low for exactly WR_CYCLES cycles.
- R6: Writing 0x20 and then 0xD0 erases the block selected by `addr[ADDR_W-1:BLK_W]` of the second cycle, setting all of its bytes to 0xFF. `ry_by` is low for exactly ER_CYCLES cycles, and other blocks are unchanged.
- R7: If the second cycle of an erase sequence carries anything other than 0xD0, the sequence is abandoned. No engine starts, and status bits 5 and 4 are set.
- R8: A program or erase second cycle is refused unless `vpp_hi` is 1 and `vpp_lo` is 0. A refused program sets status bits 4 and 3, and a refused erase sets bits 5 and 3. The array is unchanged, and reads still work.
- R9: While `vcc_low` is 1, write cycles are ignored and the data outputs are not driven.
- R10: The engine keeps running while `ce_n` is high. Write cycles are ignored while the engine is busy, including read-mode commands.
- R11: While `rp_n` is low, `ry_by` is 1 and the outputs are not driven. Deep powerdown aborts a running operation without changing the array, clears the status error bits and any half-entered sequence, and leaves the read mode at array.
- R12: A first-cycle byte that is not one of the listed commands is ignored, and the read mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| rp_n | input | 1 | Reset/powerdown, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data or command byte written by the host |
| dq_out | output | 8 | Read data (0 when not driven) |
| dq_oe | output | 1 | Drive enable for the data pads |
| ry_by | output | 1 | Ready (1) / busy (0) |
| vpp_hi | input | 1 | Program supply at programming level |
| vpp_lo | input | 1 | Program supply at lockout level |
| vcc_low | input | 1 | Core supply below write lockout |

## Verification
Two pairs of events can land on the same clock edge. The first is a command write arriving while the engine is counting, which must be dropped. The bench issues a read-array command in the first busy cycle of an erase. It then confirms that the read mode is still status and that the busy length is unchanged. The second is deep powerdown arriving while a program is in flight. The bench drops `rp_n` two cycles into a program. It then checks that `ry_by` rises at once, that the target byte still reads its old value, and that the error bits set beforehand are gone.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    typedef enum logic [2:0] {
        BM_READ,
        BM_OUT_DIS,
        BM_STANDBY,
        BM_PWRDN,
        BM_WRITE
    } bus_mode_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } rd_mode_e;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_WRITE,
        PD_ERASE
    } pend_e;

    typedef struct packed {
        logic err_erase;
        logic err_write;
        logic err_vpp;
    } stat_flags_t;

    localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_RD_ID      = 8'h90;
    localparam logic [7:0] CMD_RD_STAT    = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_WR_SETUP   = 8'h40;
    localparam logic [7:0] CMD_ER_SETUP   = 8'h20;
    localparam logic [7:0] CMD_ER_CONFIRM = 8'hD0;
    localparam logic [7:0] ID_MFR         = 8'h89;
    localparam logic [7:0] ID_DEV         = 8'hA2;

    // Pin priority: powerdown, then chip select, then output enable, then write.
    function automatic bus_mode_e decode_bus(input logic rp_n, input logic ce_n,
                                             input logic oe_n, input logic we_n);
        if (!rp_n) return BM_PWRDN;
        if (ce_n)  return BM_STANDBY;
        if (!oe_n) return BM_READ;
        if (!we_n) return BM_WRITE;
        return BM_OUT_DIS;
    endfunction

    function automatic logic [7:0] status_byte(input logic busy, input stat_flags_t f);
        return {~busy, 1'b0, f.err_erase, f.err_write, f.err_vpp, 3'b000};
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_cui_pkg::*;
(
    input  logic rp_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic vcc_low,
    output logic wr_stb,
    output logic rd_en,
    output logic pwrdn
);

    bus_mode_e mode;

    always_comb begin
        mode   = decode_bus(rp_n, ce_n, oe_n, we_n);
        pwrdn  = (mode == BM_PWRDN);
        // Supply lockout blocks both directions of the bus.
        wr_stb = (mode == BM_WRITE) && !vcc_low;
        rd_en  = (mode == BM_READ)  && !vcc_low;
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              pwrdn,
    input  logic              busy,
    input  logic              vpp_ok,
    input  logic [7:0]        din,
    input  logic [ADDR_W-1:0] addr,
    output rd_mode_e          rd_mode,
    output stat_flags_t       flags,
    output logic              start_vld,
    output logic              start_erase,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data
);

    pend_e pend;
    logic  take;

    assign take = wr_stb && !busy;

    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            rd_mode <= RM_ARRAY;
            pend    <= PD_NONE;
            flags   <= '0;
        end else if (take) begin
            unique case (pend)
                PD_WRITE: begin
                    pend <= PD_NONE;
                    if (!vpp_ok) begin
                        flags.err_write <= 1'b1;
                        flags.err_vpp   <= 1'b1;
                    end
                end
                PD_ERASE: begin
                    pend <= PD_NONE;
                    if (din != CMD_ER_CONFIRM) begin
                        flags.err_erase <= 1'b1;
                        flags.err_write <= 1'b1;
                    end else if (!vpp_ok) begin
                        flags.err_erase <= 1'b1;
                        flags.err_vpp   <= 1'b1;
                    end
                end
                default: begin
                    case (din)
                        CMD_RD_ARRAY: rd_mode <= RM_ARRAY;
                        CMD_RD_ID:    rd_mode <= RM_IDENT;
                        CMD_RD_STAT:  rd_mode <= RM_STATUS;
                        CMD_CLR_STAT: flags   <= '0;
                        CMD_WR_SETUP: begin
                            pend    <= PD_WRITE;
                            rd_mode <= RM_STATUS;
                        end
                        CMD_ER_SETUP: begin
                            pend    <= PD_ERASE;
                            rd_mode <= RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        start_erase = (pend == PD_ERASE);
        start_addr  = addr;
        start_data  = din;
        start_vld   = 1'b0;
        if (take && vpp_ok) begin
            if (pend == PD_WRITE)
                start_vld = 1'b1;
            else if (pend == PD_ERASE && din == CMD_ER_CONFIRM)
                start_vld = 1'b1;
        end
    end

endmodule

// File: rtl/flash_wr_engine.sv
module flash_wr_engine #(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 4,
    parameter int WR_CYCLES = 8,
    parameter int ER_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwrdn,
    input  logic              start_vld,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [7:0]        rd_data
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int MAX_CYC = (ER_CYCLES > WR_CYCLES) ? ER_CYCLES : WR_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0]  cnt;
    logic              op_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic              commit;
    logic [7:0]        cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            busy     <= 1'b0;
            cnt      <= '0;
            op_erase <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
        end else if (start_vld) begin
            busy     <= 1'b1;
            cnt      <= start_erase ? CNT_W'(ER_CYCLES - 1) : CNT_W'(WR_CYCLES - 1);
            op_erase <= start_erase;
            op_addr  <= start_addr;
            op_data  <= start_data;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    // The array changes only on the final busy cycle; powerdown wins over completion.
    assign commit = busy && (cnt == '0) && !pwrdn && !rst;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] ME = ADDR_W'(g);
        logic [7:0] cell_q;
        logic       hit_blk;
        logic       hit_byte;

        assign hit_blk  = (op_addr[ADDR_W-1:BLK_W] == ME[ADDR_W-1:BLK_W]);
        assign hit_byte = (op_addr == ME);

        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= 8'hFF;
            else if (commit && op_erase && hit_blk)
                cell_q <= 8'hFF;
            else if (commit && !op_erase && hit_byte)
                cell_q <= cell_q & op_data;
        end

        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_cui_core.sv
module flash_cui_core
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 4,
    parameter int WR_CYCLES = 8,
    parameter int ER_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              ry_by,
    input  logic              vpp_hi,
    input  logic              vpp_lo,
    input  logic              vcc_low
);

    logic              wr_stb;
    logic              rd_en;
    logic              pwrdn;
    logic              busy;
    logic              vpp_ok;
    rd_mode_e          rd_mode;
    stat_flags_t       flags;
    logic              start_vld;
    logic              start_erase;
    logic [ADDR_W-1:0] start_addr;
    logic [7:0]        start_data;
    logic [7:0]        arr_data;

    assign vpp_ok = vpp_hi && !vpp_lo;

    flash_bus_decode i_decode (
        .rp_n    (rp_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .vcc_low (vcc_low),
        .wr_stb  (wr_stb),
        .rd_en   (rd_en),
        .pwrdn   (pwrdn)
    );

    flash_cmd_ctrl #(.ADDR_W(ADDR_W)) i_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .pwrdn       (pwrdn),
        .busy        (busy),
        .vpp_ok      (vpp_ok),
        .din         (dq_in),
        .addr        (addr),
        .rd_mode     (rd_mode),
        .flags       (flags),
        .start_vld   (start_vld),
        .start_erase (start_erase),
        .start_addr  (start_addr),
        .start_data  (start_data)
    );

    flash_wr_engine #(
        .ADDR_W    (ADDR_W),
        .BLK_W     (BLK_W),
        .WR_CYCLES (WR_CYCLES),
        .ER_CYCLES (ER_CYCLES)
    ) i_engine (
        .clk         (clk),
        .rst         (rst),
        .pwrdn       (pwrdn),
        .start_vld   (start_vld),
        .start_erase (start_erase),
        .start_addr  (start_addr),
        .start_data  (start_data),
        .rd_addr     (addr),
        .busy        (busy),
        .rd_data     (arr_data)
    );

    always_comb begin
        dq_out = 8'h00;
        if (rd_en) begin
            case (rd_mode)
                RM_IDENT:  dq_out = addr[0] ? ID_DEV : ID_MFR;
                RM_STATUS: dq_out = status_byte(busy, flags);
                default:   dq_out = arr_data;
            endcase
        end
    end

    assign dq_oe = rd_en;
    assign ry_by = pwrdn || !busy;

endmodule

// File: rtl/flash_cui_checks.sv
module flash_cui_checks
    import flash_cui_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              rp_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              vcc_low,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_out,
    input logic              dq_oe,
    input logic              ry_by,
    input rd_mode_e          rd_mode
);

    // R2, R9
    a_r2_drive_only_in_read: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (rp_n && !ce_n && !oe_n && !vcc_low));

    // R11
    a_r11_ready_in_pwrdn: assert property (@(posedge clk) disable iff (rst)
        !rp_n |-> ry_by);

    // R11
    a_r11_array_after_pwrdn: assert property (@(posedge clk) disable iff (rst)
        !rp_n |=> (rd_mode == RM_ARRAY));

    // R3
    a_r3_ident_codes: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && rd_mode == RM_IDENT) |-> (dq_out == (addr[0] ? 8'hA2 : 8'h89)));

    // R4
    a_r4_status_layout: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && rd_mode == RM_STATUS) |->
            (dq_out[7] == ry_by && dq_out[6] == 1'b0 && dq_out[2:0] == 3'b000));

    // R10: the engine only ever starts right after an accepted write cycle
    a_r10_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by) |-> $past(rp_n && !ce_n && oe_n && !we_n && !vcc_low));

endmodule

bind flash_cui_core flash_cui_checks #(.ADDR_W(ADDR_W)) i_checks (
    .clk     (clk),
    .rst     (rst),
    .rp_n    (rp_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .vcc_low (vcc_low),
    .addr    (addr),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .ry_by   (ry_by),
    .rd_mode (rd_mode)
);

// File: tb/test_flash_cui_core.sv
`timescale 1ns/1ps
module test_flash_cui_core;

    localparam int ADDR_W = 6;
    localparam int BLK_W  = 4;
    localparam int WRC    = 8;
    localparam int ERC    = 20;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe, ry_by;
    logic              vpp_hi = 1'b1, vpp_lo = 1'b0, vcc_low = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    flash_cui_core #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WR_CYCLES(WRC), .ER_CYCLES(ERC))
        i_flash_cui_core (
        .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .ry_by(ry_by),
        .vpp_hi(vpp_hi), .vpp_lo(vpp_lo), .vcc_low(vcc_low));

    function automatic logic [7:0] exp_status(input bit fe, input bit fw, input bit fv);
        return {1'b1, 1'b0, fe, fw, fv, 3'b000};
    endfunction

    function automatic logic [7:0] exp_ident(input logic [ADDR_W-1:0] a);
        return a[0] ? 8'hA2 : 8'h89;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Each task starts at a falling edge and returns at the next one.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        ce_n = 0; oe_n = 1; we_n = 0; addr = a; dq_in = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        #1 d = dq_out; oe = dq_oe;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d; logic oe;
        rd(a, d, oe);
        check(oe === 1'b1 && d === exp, tag, {oe, d}, {1'b1, exp});
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (ry_by === 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic program_ref(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
        int n;
        wr(a, 8'h40);
        wr(a, d);
        busy_len(n);
        check(n == WRC, tag, n, WRC);
        ref_mem[a] = ref_mem[a] & d;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d; logic oe; int n;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        check(ry_by === 1'b1 && dq_oe === 1'b0, "R1", {ry_by, dq_oe}, 2'b10);
        rd_chk(6'd5, 8'hFF, "R1");

        // R3: read modes
        wr(0, 8'h90);
        rd_chk(6'd0, 8'h89, "R3");
        rd_chk(6'd1, 8'hA2, "R3");
        wr(0, 8'h70);
        rd_chk(6'd9, exp_status(0, 0, 0), "R3");
        wr(0, 8'hFF);
        rd_chk(6'd3, 8'hFF, "R3");

        // R12: unknown first-cycle byte ignored
        wr(0, 8'h90);
        wr(0, 8'h33);
        rd_chk(6'd2, 8'h89, "R12");

        // R2: read wins over write when oe_n and we_n are both low
        ce_n = 0; oe_n = 0; we_n = 0; addr = 6'd1; dq_in = 8'hFF;
        #1 check(dq_oe === 1'b1 && dq_out === 8'hA2, "R2", {dq_oe, dq_out}, 9'h1A2);
        @(negedge clk);
        we_n = 1; ce_n = 1; oe_n = 1;
        rd_chk(6'd0, 8'h89, "R2");
        // R2: disable, standby and powerdown keep the pads released
        ce_n = 0; oe_n = 1; #1 check(dq_oe === 1'b0, "R2", dq_oe, 0);
        ce_n = 1; oe_n = 0; #1 check(dq_oe === 1'b0, "R2", dq_oe, 0);
        @(negedge clk);
        oe_n = 1;
        wr(0, 8'hFF);

        // R5: byte program ANDs into the old value, status mode after setup
        wr(6'h13, 8'h40);
        rd(6'h13, d, oe);
        check(d[7] === 1'b1 && d[5:3] === 3'b000, "R5", d, 8'h80);
        wr(6'h13, 8'h3C);
        busy_len(n);
        check(n == WRC, "R5", n, WRC);
        ref_mem[6'h13] = 8'h3C;
        rd_chk(6'h13, exp_status(0, 0, 0), "R5");
        wr(0, 8'hFF);
        rd_chk(6'h13, 8'h3C, "R5");
        program_ref(6'h13, 8'hF5, "R5");
        wr(0, 8'hFF);
        rd_chk(6'h13, 8'h34, "R5");

        // R6 + R10: erase block 2 while a read-array command lands in a busy cycle
        program_ref(6'h23, 8'h5A, "R6");
        program_ref(6'h30, 8'h0F, "R6");
        wr(6'h20, 8'h20);
        wr(6'h25, 8'hD0);
        check(ry_by === 1'b0, "R6", ry_by, 0);
        wr(0, 8'hFF);
        busy_len(n);
        check(n + 1 == ERC, "R6", n + 1, ERC);
        rd_chk(6'h00, exp_status(0, 0, 0), "R10");
        wr(0, 8'hFF);
        for (int i = 32; i < 48; i++) ref_mem[i] = 8'hFF;
        rd_chk(6'h23, 8'hFF, "R6");
        rd_chk(6'h13, ref_mem[6'h13], "R6");
        rd_chk(6'h30, ref_mem[6'h30], "R6");

        // R7: bad confirm
        wr(0, 8'h20);
        wr(0, 8'h77);
        check(ry_by === 1'b1, "R7", ry_by, 1);
        rd_chk(6'h00, exp_status(1, 1, 0), "R7");
        wr(0, 8'h50);
        rd_chk(6'h00, exp_status(0, 0, 0), "R4");

        // R8: refused without program voltage
        vpp_hi = 0;
        wr(6'h05, 8'h40);
        wr(6'h05, 8'h00);
        check(ry_by === 1'b1, "R8", ry_by, 1);
        rd_chk(6'h05, exp_status(0, 1, 1), "R8");
        wr(0, 8'hFF);
        rd_chk(6'h05, 8'hFF, "R8");
        wr(0, 8'h50);
        vpp_hi = 1; vpp_lo = 1;
        wr(6'h05, 8'h20);
        wr(6'h05, 8'hD0);
        check(ry_by === 1'b1, "R8", ry_by, 1);
        rd_chk(6'h05, exp_status(1, 0, 1), "R8");
        vpp_lo = 0;
        wr(0, 8'h50);
        wr(0, 8'hFF);

        // R9: lockout
        vcc_low = 1;
        wr(0, 8'h90);
        wr(6'h06, 8'h40);
        wr(6'h06, 8'h00);
        check(ry_by === 1'b1, "R9", ry_by, 1);
        rd(6'h00, d, oe);
        check(oe === 1'b0, "R9", oe, 0);
        vcc_low = 0;
        rd_chk(6'h00, 8'hFF, "R9");
        rd_chk(6'h06, 8'hFF, "R9");

        // R11: powerdown aborts a program, clears errors and half sequences
        wr(0, 8'h20);
        wr(0, 8'h11);
        wr(6'h07, 8'h40);
        wr(6'h07, 8'h00);
        @(negedge clk);
        check(ry_by === 1'b0, "R11", ry_by, 0);
        rp_n = 0; ce_n = 0; oe_n = 0;
        #1 check(ry_by === 1'b1 && dq_oe === 1'b0, "R11", {ry_by, dq_oe}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        rp_n = 1; ce_n = 1; oe_n = 1;
        rd_chk(6'h07, 8'hFF, "R11");
        wr(0, 8'h70);
        rd_chk(6'h00, exp_status(0, 0, 0), "R11");
        wr(0, 8'h40);
        rp_n = 0; @(negedge clk); rp_n = 1;
        wr(6'h08, 8'h00);
        check(ry_by === 1'b1, "R11", ry_by, 1);
        rd_chk(6'h08, 8'hFF, "R11");

        // Random program traffic against the bench model
        for (int k = 0; k < 40; k++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] v;
            a = ADDR_W'($urandom);
            v = 8'($urandom);
            program_ref(a, v, "R5");
            if ($urandom % 2 == 0) begin
                wr(0, 8'hFF);
                rd_chk(a, ref_mem[a], "R5");
            end
            if ($urandom % 4 == 0) begin
                wr(0, 8'h90);
                rd_chk(a, exp_ident(a), "R3");
            end
        end
        wr(6'h0A, 8'h20);
        wr(6'h0A, 8'hD0);
        busy_len(n);
        check(n == ERC, "R6", n, ERC);
        for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
        wr(0, 8'hFF);
        for (int i = 0; i < DEPTH; i++) rd_chk(ADDR_W'(i), ref_mem[i], "R6");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule